// File: doc/BRIEF.md
# Leading-One Guided Approximate Multiplier

This block multiplies an N-bit activation `x` by an N-bit weight `w` at reduced cost. The weight is cut at a fixed boundary K. The upper N−K bits are multiplied by `x` exactly. The lower K bits are never multiplied as they are. A leading-one detector finds the highest set bit of the low slice, and that position picks a stand-in constant from a small family. Every member of the family is one base pattern shifted left. So the low partial product is one fixed shift-add of `x` with the base pattern, then a barrel shift chosen by the leading-one position.

Three rounding styles are chosen at build time: a group of ones, a zero-separated group, and the zero-separated group plus one compensation bit. A build option puts an approximate sign converter around the unsigned core. The result is held in an output register that loads when the enable is high. Neural-network datapaths use this block where small weight errors are acceptable in exchange for less area and energy.

Top module: `amul_top`

## Requirements
- R1: When the low K bits of the weight are zero, the unsigned result equals the exact product x·w.
- R2: With STRAT=0 (ones group), the weight slice is replaced by a word that has ones from its leading-one position t down through bit t−M+1 and zeros below. t is the leading-one index, raised to M−1 if it is smaller.
- R3: With STRAT=1 (zero-separated), the group keeps bit t set, clears bit t−1 and sets the remaining M−2 lower bits of the group. For K=4 and M=2, slices 01xx become 0100 and 1xxx become 1000.
- R4: With STRAT=2 (compensated), the STRAT=1 word also gets bit t−M set whenever the true leading-one index is at least M. For K=4 and M=2, 01xx becomes 0101 and 1xxx becomes 1010.
- R5: A nonzero slice whose leading one lies below bit M−1 maps to the base pattern placed at bit 0 (0011 for STRAT=0 with M=2). An all-zero slice contributes nothing.
- R6: The unsigned result equals x·w_hi·2^K + x·ŵ, where ŵ is the replaced slice. It lies between x·w_hi·2^K and x·w_hi·2^K + x·(2^K−1).
- R7: With SIGNED=1, a negative operand is turned into a magnitude as (~v)|1 on N bits. The unsigned core runs on the two magnitudes. When the operand sign bits differ, the 2N-bit core result u is output as (~u)|1.
- R8: With SIGNED=1, a zero `x` or a zero `w` gives a zero result.
- R9: With REG_OUT=1, the result shows on `p` one clock after the operands are presented with `en` high. While `en` is low, `p` holds its value.
- R10: While `rst_n` is low, `p` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output register |
| x | input | N | Activation (multiplicand) |
| w | input | N | Weight (multiplier), split at bit K |
| p | output | 2N | Approximate product |

## Verification
Every one of the 65,536 pairs of 8-bit operands is sent at the same time to four builds: ones group, zero-separated, compensated, and signed ones group. Weights with a zero low slice show that the exact upper path and the alignment by K are correct. Slices with a leading one at or below bit M−1 exercise the base-constant case. Slices with a leading one higher up show whether the shift amount and the three bit patterns are right, including where the compensation bit lands. In the signed build, every sign combination and zero operand are covered, which separates the input conversion, the output conversion and the forced zero. Short directed steps check the reset value, the single-cycle latency and the hold while the enable is low.

// File: rtl/amul_pkg.sv
package amul_pkg;
  localparam int STRAT_ONES  = 0;
  localparam int STRAT_ZERO  = 1;
  localparam int STRAT_ZCOMP = 2;

  // Base group for the smallest interval; every other stand-in is this shifted left.
  function automatic int base_group(int m, int strat);
    if (strat == STRAT_ONES) return (1 << m) - 1;
    if (m == 1) return 1;
    return (1 << (m - 1)) | ((1 << (m - 2)) - 1);
  endfunction
endpackage

// File: rtl/amul_lod.sv
module amul_lod #(
  parameter int W  = 4,
  parameter int IW = 3
) (
  input  logic [W-1:0]  v,
  output logic [IW-1:0] idx,
  output logic          nz
);
  always_comb begin
    idx = '0;
    nz  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) begin
        idx = IW'(i);
        nz  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/amul_approx.sv
module amul_approx
  import amul_pkg::*;
#(
  parameter int N     = 8,
  parameter int K     = 4,
  parameter int M     = 2,
  parameter int STRAT = 0
) (
  input  logic [N-1:0]   x,
  input  logic [K-1:0]   wl,
  output logic [N+K-1:0] prod
);
  localparam int IW  = $clog2(K) + 1;
  localparam int XCW = N + M;
  localparam int XW  = N + K;
  localparam logic [M-1:0]  C0   = M'(base_group(M, STRAT));
  localparam logic [IW-1:0] LOWT = IW'(M - 1);
  localparam logic [IW-1:0] MV   = IW'(M);

  logic [IW-1:0]  mso;
  logic           nz;
  logic [XCW-1:0] xc0;
  logic [IW-1:0]  sh;
  logic [XW-1:0]  shifted;
  logic [XW-1:0]  comp;

  amul_lod #(.W(K), .IW(IW)) u_lod (.v(wl), .idx(mso), .nz(nz));

  // x times the base group: a fixed sum of shifted copies of x
  always_comb begin
    xc0 = '0;
    for (int b = 0; b < M; b++) begin
      if (C0[b]) xc0 = xc0 + (XCW'(x) << b);
    end
  end

  // leading-one position selects the shift of the precomputed product
  always_comb begin
    sh      = (mso >= LOWT) ? (mso - LOWT) : '0;
    shifted = XW'(xc0) << sh;
  end

  generate
    if (STRAT == STRAT_ZCOMP) begin : g_comp
      always_comb begin
        comp = '0;
        if (mso >= MV) comp = XW'(x) << (mso - MV);
      end
    end else begin : g_nocomp
      always_comb comp = '0;
    end
  endgenerate

  always_comb prod = nz ? (shifted + comp) : '0;
endmodule

// File: rtl/amul_signconv.sv
module amul_signconv #(
  parameter int W = 8
) (
  input  logic [W-1:0] v,
  input  logic         neg,
  output logic [W-1:0] o
);
  always_comb o = neg ? ((~v) | W'(1)) : v;
endmodule

// File: rtl/amul_top.sv
module amul_top
  import amul_pkg::*;
#(
  parameter int N       = 8,
  parameter int K       = 4,
  parameter int M       = 2,
  parameter int STRAT   = STRAT_ONES,
  parameter bit SIGNED  = 1'b0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   w,
  output logic [2*N-1:0] p
);
  localparam int HW = N - K;
  localparam int EW = 2 * N - K;
  localparam int PW = 2 * N;

  logic [N-1:0]   xm, wm;
  logic [EW-1:0]  exact;
  logic [N+K-1:0] apx;
  logic [PW-1:0]  uprod;
  logic [PW-1:0]  p_d;

  generate
    if (SIGNED) begin : g_sin
      amul_signconv #(.W(N)) u_cx (.v(x), .neg(x[N-1]), .o(xm));
      amul_signconv #(.W(N)) u_cw (.v(w), .neg(w[N-1]), .o(wm));
    end else begin : g_uin
      always_comb begin
        xm = x;
        wm = w;
      end
    end
  endgenerate

  // exact upper slice
  always_comb exact = {{HW{1'b0}}, xm} * {{N{1'b0}}, wm[N-1:K]};

  amul_approx #(.N(N), .K(K), .M(M), .STRAT(STRAT)) u_apx (
    .x(xm), .wl(wm[K-1:0]), .prod(apx)
  );

  always_comb uprod = {exact, {K{1'b0}}} + PW'(apx);

  generate
    if (SIGNED) begin : g_sout
      logic neg_out, zero_op;
      logic [PW-1:0] conv;
      always_comb begin
        neg_out = x[N-1] ^ w[N-1];
        zero_op = (x == '0) || (w == '0);
      end
      amul_signconv #(.W(PW)) u_co (.v(uprod), .neg(neg_out), .o(conv));
      always_comb p_d = zero_op ? '0 : conv;
    end else begin : g_uout
      always_comb p_d = uprod;
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_reg
      logic [PW-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  p_q <= '0;
        else if (en) p_q <= p_d;
      end
      always_comb p = p_q;
    end else begin : g_comb
      always_comb p = p_d;
    end
  endgenerate
endmodule

// File: rtl/amul_chk.sv
module amul_chk #(
  parameter int N       = 8,
  parameter int K       = 4,
  parameter bit SIGNED  = 1'b0,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [N-1:0]   x,
  input logic [N-1:0]   w,
  input logic [2*N-1:0] p
);
  localparam int PW = 2 * N;
  logic [PW-1:0] xe, whe, lo_b, hi_b, full;

  always_comb begin
    xe   = PW'(x);
    whe  = PW'(w[N-1:K]) << K;
    lo_b = xe * whe;
    hi_b = lo_b + xe * PW'((1 << K) - 1);
    full = xe * PW'(w);
  end

  generate
    if (REG_OUT) begin : g_reg_chk
      // R10
      reset_zero_chk: assert property (@(posedge clk) !rst_n |-> p == '0);
      // R9
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(p));
      if (SIGNED) begin : g_s
        // R8
        zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
          en && (x == '0 || w == '0) |=> p == '0);
      end else begin : g_u
        // R1
        exact_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
          en && w[K-1:0] == '0 |=> p == $past(full));
        // R6
        lower_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
          en |=> p >= $past(lo_b));
        // R6
        upper_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
          en |=> p <= $past(hi_b));
      end
    end
  endgenerate
endmodule

bind amul_top amul_chk #(.N(N), .K(K), .SIGNED(SIGNED), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .x(x), .w(w), .p(p)
);

// File: tb/tb_amul_top.sv
module tb_amul_top;
  localparam int N = 8;
  localparam int K = 4;
  localparam int M = 2;

  logic clk, rst_n, en;
  logic [N-1:0] x, w;
  logic [2*N-1:0] p_one, p_zero, p_comp, p_sgn;
  int checks = 0, errors = 0;
  bit done = 0;

  amul_top #(.N(N), .K(K), .M(M), .STRAT(0), .SIGNED(0)) dut
    (.clk(clk), .rst_n(rst_n), .en(en), .x(x), .w(w), .p(p_one));
  amul_top #(.N(N), .K(K), .M(M), .STRAT(1), .SIGNED(0)) dut_z
    (.clk(clk), .rst_n(rst_n), .en(en), .x(x), .w(w), .p(p_zero));
  amul_top #(.N(N), .K(K), .M(M), .STRAT(2), .SIGNED(0)) dut_c
    (.clk(clk), .rst_n(rst_n), .en(en), .x(x), .w(w), .p(p_comp));
  amul_top #(.N(N), .K(K), .M(M), .STRAT(0), .SIGNED(1)) dut_s
    (.clk(clk), .rst_n(rst_n), .en(en), .x(x), .w(w), .p(p_sgn));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int lead(int v);
    int r = -1;
    for (int i = 0; i < K; i++) if ((v >> i) & 1) r = i;
    return r;
  endfunction

  // replacement word for a K-bit slice, built bit by bit from the requirement text
  function automatic int repl(int v, int strat);
    int t, r, ms;
    if (v == 0) return 0;
    ms = lead(v);
    t  = (ms < M - 1) ? M - 1 : ms;
    r  = 1 << t;
    for (int i = 1; i < M; i++)
      if (strat == 0 || i != 1) r = r | (1 << (t - i));
    if (strat == 2 && ms >= M) r = r | (1 << (t - M));
    return r;
  endfunction

  function automatic int umodel(int xv, int wv, int strat);
    return xv * ((wv >> K) << K) + xv * repl(wv & ((1 << K) - 1), strat);
  endfunction

  function automatic int smodel(int xv, int wv);
    int mx, mw, u;
    if (xv == 0 || wv == 0) return 0;
    mx = ((xv >> (N - 1)) & 1) ? ((~xv | 1) & 8'hFF) : xv;
    mw = ((wv >> (N - 1)) & 1) ? ((~wv | 1) & 8'hFF) : wv;
    u  = umodel(mx, mw, 0);
    if ((((xv ^ wv) >> (N - 1)) & 1) == 1) return (~u | 1) & 16'hFFFF;
    return u;
  endfunction

  task automatic chk(string req, int got, int exp, int xv, int wv);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s x=%0d w=%0d got=%0d exp=%0d", req, xv, wv, got, exp);
    end
  endtask

  task automatic check_all(int xv, int wv);
    int lo, base, ms;
    lo = wv & ((1 << K) - 1);
    ms = lead(lo);
    if (lo == 0) chk("R1", int'(p_one), xv * wv, xv, wv);
    else if (ms < M - 1) chk("R5", int'(p_one), umodel(xv, wv, 0), xv, wv);
    else chk("R2", int'(p_one), umodel(xv, wv, 0), xv, wv);
    chk("R3", int'(p_zero), umodel(xv, wv, 1), xv, wv);
    chk("R4", int'(p_comp), umodel(xv, wv, 2), xv, wv);
    base = xv * ((wv >> K) << K);
    checks++;
    if (int'(p_comp) < base || int'(p_comp) > base + xv * ((1 << K) - 1)) begin
      errors++;
      $display("FAIL R6 x=%0d w=%0d got=%0d exp=[%0d,%0d]", xv, wv, p_comp, base,
               base + xv * ((1 << K) - 1));
    end
    if (xv == 0 || wv == 0) chk("R8", int'(p_sgn), 0, xv, wv);
    else chk("R7", int'(p_sgn), smodel(xv, wv), xv, wv);
  endtask

  initial begin
    int px, pw, held;
    rst_n = 1'b0; en = 1'b0; x = '0; w = '0;
    repeat (3) @(negedge clk);
    x = 8'd77; w = 8'd201; en = 1'b1;
    @(negedge clk);
    // R10: still in reset despite enabled operands
    chk("R10", int'(p_one), 0, 77, 201);
    chk("R10", int'(p_sgn), 0, 77, 201);
    rst_n = 1'b1;
    px = 0; pw = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) check_all(px, pw);
      x = N'(i >> 8); w = N'(i & 8'hFF);
      px = i >> 8; pw = i & 8'hFF;
    end
    @(negedge clk);
    check_all(px, pw);
    // R9: one-cycle latency, then hold while en is low
    x = 8'd3; w = 8'd5;
    @(negedge clk);
    chk("R9", int'(p_one), umodel(3, 5, 0), 3, 5);
    held = int'(p_one);
    en = 1'b0; x = 8'd200; w = 8'd255;
    repeat (2) @(negedge clk);
    chk("R9", int'(p_one), held, 200, 255);
    chk("R9", int'(p_comp), umodel(3, 5, 2), 200, 255);
    en = 1'b1;
    @(negedge clk);
    chk("R9", int'(p_one), umodel(200, 255, 0), 200, 255);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule